// File: doc/BRIEF.md
# Keyboard and Character Display Register Interface

This block sits on a 16-bit processor bus and presents four device registers at fixed addresses. Two are for a keyboard (status and data) and two are for a character display (status and data). A keyboard source strobes an 8-bit character code into the block. A display sink receives one character at a time and signals when it has taken it. Software can poll the ready flags or take an interrupt, because each device raises a request whenever its ready flag and its enable bit are both set.

Only hardware events and data-register accesses move the ready flags. A key strike sets keyboard ready and locks out further strikes. A bus read of keyboard data clears keyboard ready and releases the lock. A bus write of display data takes display ready low until the sink reports completion. Software can write only the enable bits in the status registers.

Top module: `char_io_regs`

## Requirements
- R1: Keyboard status is at 16'hFE00, keyboard data at 16'hFE02, display status at 16'hFE04 and display data at 16'hFE06. A status read returns ready in bit 15, enable in bit 14 and zeros in bits 13:0. A data read returns the character in bits 7:0 and zeros in bits 15:8. `busRdata` is 0 when `busRd` is low or when the address is unmapped.
- R2: When `keyStrobe` is high and keyboard ready is 0, the block latches `keyCode` into keyboard data and sets keyboard ready at that clock edge.
- R3: When keyboard ready is 1, `keyStrobe` has no effect, so keyboard data keeps the first character.
- R4: A bus read of keyboard data while keyboard ready is 1 clears keyboard ready at that edge. The next strike is then accepted.
- R5: A bus write of display data while display ready is 1 latches bits 7:0 onto `dispChar` and clears display ready at that edge. `dispValid` is the inverse of display ready.
- R6: When `dispDone` is high while display ready is 0, display ready returns to 1 at that edge. When display ready is already 1, `dispDone` has no effect.
- R7: A bus write of display data while display ready is 0 is dropped. `dispChar` stays stable until `dispDone`.
- R8: A bus write to either status register loads bit 14 into that device's enable bit. Bit 15 and all other written bits are ignored.
- R9: `kbdIrq` equals keyboard ready AND keyboard enable, and `dispIrq` equals display ready AND display enable.
- R10: After reset, keyboard ready is 0, display ready is 1, both enables are 0, and both data registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Bus address |
| busRd | input | 1 | Bus read strobe, one cycle per access |
| busWr | input | 1 | Bus write strobe, one cycle per access |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Bus read data, combinational from the address |
| keyStrobe | input | 1 | Key struck, with the code on keyCode |
| keyCode | input | 8 | Character code of the struck key |
| dispValid | output | 1 | A character is in flight to the display |
| dispChar | output | 8 | Character offered to the display |
| dispDone | input | 1 | Display sink has finished the character |
| kbdIrq | output | 1 | Keyboard interrupt request |
| dispIrq | output | 1 | Display interrupt request |

## Verification
A wrong ready flag shows up on the interrupt outputs in the cycle after the event that set it, and on the next status read. A broken lock shows up as a changed keyboard data value on the read that follows a second strike. A display write that is not dropped while busy shows up on `dispChar` one cycle later. The bench compares every output on every clock against a behavioural model, so a divergence is reported in the first cycle where it becomes visible at the ports.

// File: rtl/char_io_pkg.sv
package char_io_pkg;

  typedef enum logic [2:0] {
    SEL_NONE      = 3'd0,
    SEL_KBD_STAT  = 3'd1,
    SEL_KBD_DATA  = 3'd2,
    SEL_DISP_STAT = 3'd3,
    SEL_DISP_DATA = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   kbdStatWr;
    logic   kbdDataRd;
    logic   dispStatWr;
    logic   dispDataWr;
    rdSel_e rdSel;
  } ioStrobes_t;

endpackage

// File: rtl/char_io_ctrl.sv
module char_io_ctrl
  import char_io_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'hFE00
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output ioStrobes_t        strobes
);
  localparam logic [ADDR_W-1:0] KBD_STAT_A  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] KBD_DATA_A  = ADDR_W'(BASE_ADDR + 16'd2);
  localparam logic [ADDR_W-1:0] DISP_STAT_A = ADDR_W'(BASE_ADDR + 16'd4);
  localparam logic [ADDR_W-1:0] DISP_DATA_A = ADDR_W'(BASE_ADDR + 16'd6);

  logic hitKbdStat, hitKbdData, hitDispStat, hitDispData;

  always_comb begin
    hitKbdStat  = (busAddr == KBD_STAT_A);
    hitKbdData  = (busAddr == KBD_DATA_A);
    hitDispStat = (busAddr == DISP_STAT_A);
    hitDispData = (busAddr == DISP_DATA_A);
  end

  always_comb begin
    strobes.kbdStatWr  = busWr && hitKbdStat;
    strobes.kbdDataRd  = busRd && hitKbdData;
    strobes.dispStatWr = busWr && hitDispStat;
    strobes.dispDataWr = busWr && hitDispData;
    strobes.rdSel      = SEL_NONE;
    if (busRd) begin
      unique case (1'b1)
        hitKbdStat:  strobes.rdSel = SEL_KBD_STAT;
        hitKbdData:  strobes.rdSel = SEL_KBD_DATA;
        hitDispStat: strobes.rdSel = SEL_DISP_STAT;
        hitDispData: strobes.rdSel = SEL_DISP_DATA;
        default:     strobes.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/char_io_datapath.sv
module char_io_datapath
  import char_io_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strobes,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              keyStrobe,
  input  logic [CHAR_W-1:0] keyCode,
  input  logic              dispDone,
  output logic [CHAR_W-1:0] dispChar,
  output logic              kbdReady,
  output logic              kbdIe,
  output logic              dispReady,
  output logic              dispIe
);
  localparam int READY_BIT = DATA_W - 1;
  localparam int IE_BIT    = DATA_W - 2;

  logic [CHAR_W-1:0] kbdData;
  logic              unusedWdata;

  assign unusedWdata = ^{busWdata[READY_BIT], busWdata[IE_BIT-1:CHAR_W]};

  // Keyboard: ready doubles as the strike lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdReady <= 1'b0;
      kbdData  <= '0;
    end else if (kbdReady) begin
      if (strobes.kbdDataRd) kbdReady <= 1'b0;
    end else if (keyStrobe) begin
      kbdReady <= 1'b1;
      kbdData  <= keyCode;
    end
  end

  // Display: a write is accepted only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispReady <= 1'b1;
      dispChar  <= '0;
    end else if (dispReady) begin
      if (strobes.dispDataWr) begin
        dispReady <= 1'b0;
        dispChar  <= busWdata[CHAR_W-1:0];
      end
    end else if (dispDone) begin
      dispReady <= 1'b1;
    end
  end

  // Software-owned enable bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdIe  <= 1'b0;
      dispIe <= 1'b0;
    end else begin
      if (strobes.kbdStatWr)  kbdIe  <= busWdata[IE_BIT];
      if (strobes.dispStatWr) dispIe <= busWdata[IE_BIT];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strobes.rdSel)
      SEL_KBD_STAT: begin
        busRdata[READY_BIT] = kbdReady;
        busRdata[IE_BIT]    = kbdIe;
      end
      SEL_KBD_DATA:  busRdata[CHAR_W-1:0] = kbdData;
      SEL_DISP_STAT: begin
        busRdata[READY_BIT] = dispReady;
        busRdata[IE_BIT]    = dispIe;
      end
      SEL_DISP_DATA: busRdata[CHAR_W-1:0] = dispChar;
      default:       busRdata = '0;
    endcase
  end

endmodule

// File: rtl/char_io_regs.sv
module char_io_regs
  import char_io_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int          CHAR_W    = 8,
  parameter logic [15:0] BASE_ADDR = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              keyStrobe,
  input  logic [CHAR_W-1:0] keyCode,
  output logic              dispValid,
  output logic [CHAR_W-1:0] dispChar,
  input  logic              dispDone,
  output logic              kbdIrq,
  output logic              dispIrq
);
  ioStrobes_t strobes;
  logic kbdReady, kbdIe, dispReady, dispIe;

  char_io_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes)
  );

  char_io_datapath #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .keyStrobe (keyStrobe),
    .keyCode   (keyCode),
    .dispDone  (dispDone),
    .dispChar  (dispChar),
    .kbdReady  (kbdReady),
    .kbdIe     (kbdIe),
    .dispReady (dispReady),
    .dispIe    (dispIe)
  );

  assign dispValid = !dispReady;
  assign kbdIrq    = kbdReady && kbdIe;
  assign dispIrq   = dispReady && dispIe;

endmodule

// File: rtl/char_io_regs_chk.sv
module char_io_regs_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int          CHAR_W    = 8,
  parameter logic [15:0] BASE_ADDR = 16'hFE00
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic              keyStrobe,
  input logic              dispDone,
  input logic              dispValid,
  input logic [CHAR_W-1:0] dispChar,
  input logic              kbdReady,
  input logic              kbdIe
);
  localparam logic [ADDR_W-1:0] KS_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] KD_A = ADDR_W'(BASE_ADDR + 16'd2);
  localparam logic [ADDR_W-1:0] DD_A = ADDR_W'(BASE_ADDR + 16'd6);

  assert_key_sets_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe && !kbdReady |=> kbdReady);

  assert_read_clears_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == KD_A && kbdReady |=> !kbdReady);

  assert_write_launches_char_R5: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == DD_A && !dispValid |=>
      dispValid && dispChar == $past(busWdata[CHAR_W-1:0]));

  assert_done_frees_display_R6: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispDone |=> !dispValid);

  assert_char_held_in_flight_R7: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && !dispDone |=> dispValid && $stable(dispChar));

  assert_enable_written_R8: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == KS_A |=> kbdIe == $past(busWdata[DATA_W-2]));

endmodule

bind char_io_regs char_io_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .keyStrobe (keyStrobe),
  .dispDone  (dispDone),
  .dispValid (dispValid),
  .dispChar  (dispChar),
  .kbdReady  (kbdReady),
  .kbdIe     (kbdIe)
);

// File: tb/char_io_regs_tb.sv
module char_io_regs_tb;
  localparam int PERIOD = 10;
  localparam logic [15:0] KS = 16'hFE00, KD = 16'hFE02, DS = 16'hFE04, DD = 16'hFE06;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        keyStrobe = 1'b0;
  logic [7:0]  keyCode = '0;
  logic        dispValid;
  logic [7:0]  dispChar;
  logic        dispDone = 1'b0;
  logic        kbdIrq, dispIrq;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R10";

  // reference model state
  bit       mKR = 0, mKIe = 0, mDR = 1, mDIe = 0;
  bit [7:0] mKD = 0, mDC = 0;

  always #(PERIOD/2) clk = ~clk;

  char_io_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .keyStrobe(keyStrobe),
    .keyCode(keyCode), .dispValid(dispValid), .dispChar(dispChar),
    .dispDone(dispDone), .kbdIrq(kbdIrq), .dispIrq(dispIrq)
  );

  function automatic logic [15:0] modelRead();
    if (!busRd) return 16'h0;
    case (busAddr)
      KS: return {mKR, mKIe, 14'h0};
      KD: return {8'h0, mKD};
      DS: return {mDR, mDIe, 14'h0};
      DD: return {8'h0, mDC};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("busRdata", busRdata, modelRead());
    check("kbdIrq", {15'h0, kbdIrq}, {15'h0, mKR & mKIe});
    check("dispIrq", {15'h0, dispIrq}, {15'h0, mDR & mDIe});
    check("dispValid", {15'h0, dispValid}, {15'h0, ~mDR});
    check("dispChar", {8'h0, dispChar}, {8'h0, mDC});
  endtask

  task automatic modelStep();
    if (mKR) begin
      if (busRd && busAddr == KD) mKR = 0;
    end else if (keyStrobe) begin
      mKR = 1; mKD = keyCode;
    end
    if (mDR) begin
      if (busWr && busAddr == DD) begin mDR = 0; mDC = busWdata[7:0]; end
    end else if (dispDone) mDR = 1;
    if (busWr && busAddr == KS) mKIe = busWdata[14];
    if (busWr && busAddr == DS) mDIe = busWdata[14];
  endtask

  task automatic cycle(input bit rd, input bit wr, input logic [15:0] a,
                       input logic [15:0] wd, input bit ks, input logic [7:0] kc,
                       input bit dn);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWdata = wd;
    keyStrobe = ks; keyCode = kc; dispDone = dn;
    #1 compareAll();
    @(posedge clk);
    modelStep();
  endtask

  task automatic rd(input logic [15:0] a);  cycle(1, 0, a, 16'h0, 0, 8'h0, 0); endtask
  task automatic wr(input logic [15:0] a, input logic [15:0] d); cycle(0, 1, a, d, 0, 8'h0, 0); endtask
  task automatic key(input logic [7:0] c);  cycle(0, 0, 16'h0, 16'h0, 1, c, 0); endtask
  task automatic done();                    cycle(0, 0, 16'h0, 16'h0, 0, 8'h0, 1); endtask
  task automatic idle();                    cycle(0, 0, 16'h0, 16'h0, 0, 8'h0, 0); endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R10 reset state
    curReq = "R10";
    rd(KS); rd(DS); rd(KD); rd(DD);
    // R1 map and zero fill, unmapped address
    curReq = "R1";
    rd(16'hFE08); rd(16'hFE01); idle();
    // R8 enables, ready bit not writable
    curReq = "R8";
    wr(KS, 16'hFFFF); rd(KS); wr(KS, 16'h8000); rd(KS);
    wr(DS, 16'h4000); rd(DS); wr(DS, 16'h3FFF); rd(DS);
    // R2 strike latches and sets ready
    curReq = "R2";
    key(8'h41); rd(KS); rd(KD);
    // R9 interrupt follows ready and enable
    curReq = "R9";
    wr(KS, 16'h4000); idle(); wr(DS, 16'h4000); idle();
    // R3 strike while locked ignored
    curReq = "R3";
    key(8'h42); idle(); rd(KD);
    // R4 read cleared ready; next strike accepted
    curReq = "R4";
    rd(KS); key(8'h43); rd(KS); rd(KD); rd(KS);
    // R5 display write
    curReq = "R5";
    wr(DD, 16'hAB48); idle(); rd(DD); rd(DS);
    // R7 write while busy dropped
    curReq = "R7";
    wr(DD, 16'h0058); idle(); rd(DD);
    // R6 completion, and done while idle ignored
    curReq = "R6";
    done(); rd(DS); done(); idle(); wr(DD, 16'h0059); done(); done(); rd(DD);
    // mixed traffic
    curReq = "R9";
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] a;
      sel = $urandom_range(0, 4);
      a = (sel == 4) ? 16'hFE0A : (16'hFE00 + 16'(sel * 2));
      cycle($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, a,
            16'($urandom), $urandom_range(0, 2) == 0, 8'($urandom),
            $urandom_range(0, 2) == 0);
    end
    idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule